// File: doc/BRIEF.md
# Computation Unit Operand Manager

This block sits between the issue stage, the register-file ports and one attached execution unit. It takes an operation on a single-cycle issue pulse and latches it. It then drives a busy flag and raises a read request on each source port that needs a value from the register file. A one-cycle go pulse on a port delivers that operand. In the go cycle the operand is also passed straight through to the execution-unit input.

Once every requested operand has arrived, the block starts the execution unit with a valid/ready handshake and waits for the result strobe. It then raises a write request and drives the result on the destination port. A one-cycle write go pulse means the result has been stored. Busy covers the whole span from issue to that pulse, so the scheduler always knows that a result is still outstanding.

Some operands need no register read. An immediate can replace the second operand, a zero flag can replace the first operand, and a per-port read mask can leave any operand out. No read request is raised for an operand that is replaced or masked.

Top module: `opmgr_unit`

## Requirements
- R1: After reset and while no issue pulse has been taken, busy_o is low. busy_o rises in the cycle after issue_i is sampled high while busy_o is low, and it never rises without an issue pulse. The issuer keeps issue_i low while busy_o is high.
- R2: The operation code, immediate value, immediate flag, zero flag and read mask are latched in the issue cycle. Changing op_func_i, op_imm_i, op_imm_en_i or op_zero_a_i after that cycle has no effect on the operation.
- R3: The read request of each port that needs a value rises in the cycle after issue. It stays high through any number of stall cycles until its go input is sampled high, and it is low in the cycle after that go.
- R4: A port's operand is captured only in a cycle where its read request and its go input are both high. In that cycle the source value appears on that port's slice of ex_opnd_o. A go pulse on a port whose request is low changes nothing.
- R5: When op_imm_en_i is set at issue, operand 1 equals op_imm_i and port 1 raises no read request, whatever its mask bit is.
- R6: When op_zero_a_i is set at issue, operand 0 is zero and port 0 raises no read request, whatever its mask bit is.
- R7: A set bit i in op_rd_mask_i (bit i belongs to source port i) suppresses the read request of port i, and operand i is then zero, unless R5 or R6 applies to that port.
- R8: Once a port's go has been accepted, its read request does not rise again while busy_o stays high.
- R9: ex_valid_o is high only once no read request is pending. It stays high until ex_ready_i is sampled high. While it is high, ex_op_o carries the latched operation code and ex_opnd_o carries all operands.
- R10: After ex_res_valid_i, wr_req_o rises and dest_o carries ex_result_i. A wr_go_i pulse while wr_req_o is high makes busy_o and wr_req_o low in the next cycle.
- R11: Reset clears busy_o, every read request, ex_valid_o and wr_req_o.
- R12: When every handshake answers without stalls, an operation finishes (busy_o low again) within 50 cycles of its issue pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_i | input | 1 | One-cycle issue pulse |
| op_func_i | input | FUNC_W | Operation code, passed on to the execution unit |
| op_imm_i | input | DATA_W | Immediate value for operand 1 |
| op_imm_en_i | input | 1 | Use the immediate as operand 1 |
| op_zero_a_i | input | 1 | Force operand 0 to zero |
| op_rd_mask_i | input | NSRC | Per-port read suppression, bit i for port i |
| busy_o | output | 1 | Operation in flight, from issue to writeback |
| rd_req_o | output | NSRC | Per-port read request |
| rd_go_i | input | NSRC | Per-port one-cycle read go |
| src_data_i | input | NSRC*DATA_W | Source operands, port i at bits i*DATA_W upward |
| ex_valid_o | output | 1 | Operands ready for the execution unit |
| ex_ready_i | input | 1 | Execution unit accepts the operands |
| ex_op_o | output | FUNC_W | Latched operation code |
| ex_opnd_o | output | NSRC*DATA_W | Operands to the execution unit |
| ex_res_valid_i | input | 1 | Execution unit result strobe |
| ex_result_i | input | DATA_W | Execution unit result |
| wr_req_o | output | 1 | Write request for the destination port |
| wr_go_i | input | 1 | One-cycle write go, result stored |
| dest_o | output | DATA_W | Result for the register file, zero when no write is requested |

## Verification
The bench builds the unit with three source ports, 16-bit data and a 4-bit operation code. With three ports it can run immediate, zero and mask substitution on different ports in the same operation. It can also mask every port, which takes the unit straight from issue to the execution-unit launch. The 16-bit width leaves room for operand values that show which port each result came from, and for a marker value on ignored go pulses that would show up if it leaked into a result. The four operation codes give the bench's execution model distinct add, subtract, shift and XOR results, so a swapped or stale operand produces a wrong result.

// File: rtl/opmgr_pkg.sv
package opmgr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_COLLECT = 3'd1,
        ST_LAUNCH  = 3'd2,
        ST_AWAIT   = 3'd3,
        ST_WRITE   = 3'd4
    } opmgr_state_t;

    typedef struct packed {
        logic imm_en;
        logic zero_a;
    } opmgr_flags_t;

    // Port 0 is the zero-able operand, port 1 the immediate-able operand.
    function automatic logic need_read(input int idx, input opmgr_flags_t fl,
                                       input logic masked);
        logic keep;
        keep = !masked;
        if (idx == 0 && fl.zero_a) keep = 1'b0;
        if (idx == 1 && fl.imm_en) keep = 1'b0;
        return keep;
    endfunction

endpackage

// File: rtl/opmgr_rdport.sv
module opmgr_rdport
    import opmgr_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int IDX    = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              issue_fire,
    input  opmgr_flags_t      flags,
    input  logic              masked,
    input  logic [DATA_W-1:0] imm_val,
    input  logic              go,
    input  logic [DATA_W-1:0] src,
    output logic              req,
    output logic [DATA_W-1:0] opnd
);
    logic [DATA_W-1:0] opnd_q;
    logic [DATA_W-1:0] preset;
    logic              take;

    assign take = req && go;

    generate
        if (IDX == 1) begin : g_imm
            assign preset = flags.imm_en ? imm_val : '0;
        end else begin : g_zero
            assign preset = (imm_val & '0);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            req    <= 1'b0;
            opnd_q <= '0;
        end else if (issue_fire) begin
            req    <= need_read(IDX, flags, masked);
            opnd_q <= preset;
        end else if (take) begin
            req    <= 1'b0;
            opnd_q <= src;
        end
    end

    assign opnd = take ? src : opnd_q;
endmodule

// File: rtl/opmgr_seq.sv
module opmgr_seq
    import opmgr_pkg::*;
#(
    parameter int FUNC_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              issue_i,
    input  logic [FUNC_W-1:0] func_i,
    input  logic              reads_done,
    input  logic              ex_ready_i,
    input  logic              ex_res_valid_i,
    input  logic              wr_go_i,
    output logic              issue_fire,
    output logic              busy,
    output logic              ex_valid,
    output logic              res_load,
    output logic              wr_req,
    output logic [FUNC_W-1:0] func_q
);
    opmgr_state_t state, nxt;

    assign issue_fire = issue_i && (state == ST_IDLE);
    assign busy       = (state != ST_IDLE);
    assign ex_valid   = (state == ST_LAUNCH);
    assign wr_req     = (state == ST_WRITE);
    assign res_load   = (state == ST_AWAIT) && ex_res_valid_i;

    always_comb begin
        nxt = state;
        case (state)
            ST_IDLE:    if (issue_i)        nxt = ST_COLLECT;
            ST_COLLECT: if (reads_done)     nxt = ST_LAUNCH;
            ST_LAUNCH:  if (ex_ready_i)     nxt = ST_AWAIT;
            ST_AWAIT:   if (ex_res_valid_i) nxt = ST_WRITE;
            ST_WRITE:   if (wr_go_i)        nxt = ST_IDLE;
            default:                        nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            func_q <= '0;
        end else begin
            state <= nxt;
            if (issue_fire) func_q <= func_i;
        end
    end
endmodule

// File: rtl/opmgr_wrport.sv
module opmgr_wrport #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] result_i,
    input  logic              wr_req,
    output logic [DATA_W-1:0] dest
);
    logic [DATA_W-1:0] res_q;

    always_ff @(posedge clk) begin
        if (rst)       res_q <= '0;
        else if (load) res_q <= result_i;
    end

    assign dest = wr_req ? res_q : '0;
endmodule

// File: rtl/opmgr_unit.sv
module opmgr_unit
    import opmgr_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int FUNC_W = 4,
    parameter int NSRC   = 3
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   issue_i,
    input  logic [FUNC_W-1:0]      op_func_i,
    input  logic [DATA_W-1:0]      op_imm_i,
    input  logic                   op_imm_en_i,
    input  logic                   op_zero_a_i,
    input  logic [NSRC-1:0]        op_rd_mask_i,
    output logic                   busy_o,
    output logic [NSRC-1:0]        rd_req_o,
    input  logic [NSRC-1:0]        rd_go_i,
    input  logic [NSRC*DATA_W-1:0] src_data_i,
    output logic                   ex_valid_o,
    input  logic                   ex_ready_i,
    output logic [FUNC_W-1:0]      ex_op_o,
    output logic [NSRC*DATA_W-1:0] ex_opnd_o,
    input  logic                   ex_res_valid_i,
    input  logic [DATA_W-1:0]      ex_result_i,
    output logic                   wr_req_o,
    input  logic                   wr_go_i,
    output logic [DATA_W-1:0]      dest_o
);
    localparam int OPND_W = NSRC * DATA_W;

    logic         issue_fire;
    logic         res_load;
    logic         reads_done;
    opmgr_flags_t flags;

    assign flags.imm_en = op_imm_en_i;
    assign flags.zero_a = op_zero_a_i;
    assign reads_done   = ~|rd_req_o;

    opmgr_seq #(.FUNC_W(FUNC_W)) u_seq (
        .clk            (clk),
        .rst            (rst),
        .issue_i        (issue_i),
        .func_i         (op_func_i),
        .reads_done     (reads_done),
        .ex_ready_i     (ex_ready_i),
        .ex_res_valid_i (ex_res_valid_i),
        .wr_go_i        (wr_go_i),
        .issue_fire     (issue_fire),
        .busy           (busy_o),
        .ex_valid       (ex_valid_o),
        .res_load       (res_load),
        .wr_req         (wr_req_o),
        .func_q         (ex_op_o)
    );

    generate
        for (genvar i = 0; i < NSRC; i++) begin : g_port
            opmgr_rdport #(.DATA_W(DATA_W), .IDX(i)) u_rd (
                .clk        (clk),
                .rst        (rst),
                .issue_fire (issue_fire),
                .flags      (flags),
                .masked     (op_rd_mask_i[i]),
                .imm_val    (op_imm_i),
                .go         (rd_go_i[i]),
                .src        (src_data_i[i*DATA_W +: DATA_W]),
                .req        (rd_req_o[i]),
                .opnd       (ex_opnd_o[i*DATA_W +: DATA_W])
            );
        end
    endgenerate

    opmgr_wrport #(.DATA_W(DATA_W)) u_wr (
        .clk      (clk),
        .rst      (rst),
        .load     (res_load),
        .result_i (ex_result_i),
        .wr_req   (wr_req_o),
        .dest     (dest_o)
    );

    logic [OPND_W-1:0] unused_w;
    assign unused_w = '0;
endmodule

// File: rtl/opmgr_chk.sv
module opmgr_chk #(
    parameter int NSRC = 3
) (
    input logic            clk,
    input logic            rst,
    input logic            issue_i,
    input logic            busy_o,
    input logic [NSRC-1:0] rd_req_o,
    input logic [NSRC-1:0] rd_go_i,
    input logic            ex_valid_o,
    input logic            ex_ready_i,
    input logic            wr_req_o,
    input logic            wr_go_i
);
    AST_BUSY_AFTER_ISSUE: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && issue_i) |=> busy_o); // R1
    AST_NO_SELF_BUSY: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && !issue_i) |=> !busy_o); // R1
    AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> (rd_req_o == '0 && !ex_valid_o && !wr_req_o)); // R11
    AST_LAUNCH_AFTER_READS: assert property (@(posedge clk) disable iff (rst)
        ex_valid_o |-> (rd_req_o == '0)); // R9
    AST_LAUNCH_HELD: assert property (@(posedge clk) disable iff (rst)
        (ex_valid_o && !ex_ready_i) |=> ex_valid_o); // R9
    AST_WRITE_ENDS: assert property (@(posedge clk) disable iff (rst)
        (wr_req_o && wr_go_i) |=> (!busy_o && !wr_req_o)); // R10

    generate
        for (genvar i = 0; i < NSRC; i++) begin : g_chk
            AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
                (rd_req_o[i] && !rd_go_i[i]) |=> rd_req_o[i]); // R3
            AST_REQ_DROPS: assert property (@(posedge clk) disable iff (rst)
                (rd_req_o[i] && rd_go_i[i]) |=> !rd_req_o[i]); // R3
            AST_REQ_NO_RERISE: assert property (@(posedge clk) disable iff (rst)
                (busy_o && !rd_req_o[i]) |=> !rd_req_o[i]); // R8
        end
    endgenerate
endmodule

bind opmgr_unit opmgr_chk #(.NSRC(NSRC)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .issue_i    (issue_i),
    .busy_o     (busy_o),
    .rd_req_o   (rd_req_o),
    .rd_go_i    (rd_go_i),
    .ex_valid_o (ex_valid_o),
    .ex_ready_i (ex_ready_i),
    .wr_req_o   (wr_req_o),
    .wr_go_i    (wr_go_i)
);

// File: tb/sim_opmgr_unit.sv
`timescale 1ns/1ps
module sim_opmgr_unit;
    localparam int DW = 16;
    localparam int FW = 4;
    localparam int NS = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          issue_i = 1'b0;
    logic [FW-1:0] op_func_i = '0;
    logic [DW-1:0] op_imm_i = '0;
    logic          op_imm_en_i = 1'b0;
    logic          op_zero_a_i = 1'b0;
    logic [NS-1:0] op_rd_mask_i = '0;
    logic          busy_o;
    logic [NS-1:0] rd_req_o;
    logic [NS-1:0] rd_go_i = '0;
    logic [NS*DW-1:0] src_data_i = '0;
    logic          ex_valid_o;
    logic          ex_ready_i = 1'b0;
    logic [FW-1:0] ex_op_o;
    logic [NS*DW-1:0] ex_opnd_o;
    logic          ex_res_valid_i = 1'b0;
    logic [DW-1:0] ex_result_i = '0;
    logic          wr_req_o;
    logic          wr_go_i = 1'b0;
    logic [DW-1:0] dest_o;

    always #2.5 clk = ~clk;

    opmgr_unit #(.DATA_W(DW), .FUNC_W(FW), .NSRC(NS)) u0 (.*);

    int n_chk = 0;
    int n_fail = 0;
    logic [DW-1:0] exp_q[$];
    logic [FW-1:0] cur_func = '0;
    int ex_stall = 0;
    int wr_dly = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] calc(input logic [FW-1:0] f,
        input logic [DW-1:0] a, input logic [DW-1:0] b, input logic [DW-1:0] c);
        case (f)
            4'd0:    return a + b + c;
            4'd1:    return a - b;
            4'd2:    return a << b[3:0];
            default: return a ^ b ^ c;
        endcase
    endfunction

    // Execution unit model: takes operands on valid/ready, answers 2 cycles later.
    initial begin
        int cnt;
        logic [NS*DW-1:0] snap;
        logic [FW-1:0] fsnap;
        cnt = 0;
        forever begin
            @(negedge clk);
            if (ex_valid_o) begin
                chk(rd_req_o == '0, "R9 launch with reads pending", rd_req_o, 0);
                if (cnt >= ex_stall) begin
                    ex_ready_i = 1'b1;
                    snap  = ex_opnd_o;
                    fsnap = ex_op_o;
                    chk(ex_op_o == cur_func, "R2 latched op code", ex_op_o, cur_func);
                    @(negedge clk);
                    ex_ready_i = 1'b0;
                    cnt = 0;
                    chk(!ex_valid_o, "R9 valid drops after ready", ex_valid_o, 0);
                    @(negedge clk);
                    ex_res_valid_i = 1'b1;
                    ex_result_i = calc(fsnap, snap[0 +: DW], snap[DW +: DW], snap[2*DW +: DW]);
                    @(negedge clk);
                    ex_res_valid_i = 1'b0;
                end else begin
                    cnt++;
                end
            end
        end
    end

    // Scoreboard monitor: answers the write request and compares the result.
    initial begin
        logic [DW-1:0] e;
        forever begin
            @(negedge clk);
            if (wr_req_o) begin
                repeat (wr_dly) begin
                    @(negedge clk);
                    chk(wr_req_o, "R10 write request held", wr_req_o, 1);
                end
                e = (exp_q.size() > 0) ? exp_q.pop_front() : 'x;
                chk(dest_o == e, "R10 result on destination", dest_o, e);
                wr_go_i = 1'b1;
                @(negedge clk);
                wr_go_i = 1'b0;
                chk(!busy_o && !wr_req_o, "R10 busy falls after write go",
                    {busy_o, wr_req_o}, 0);
            end
        end
    end

    task automatic serve(input int idx, input bit want, input logic [DW-1:0] val,
                         input int dly, input bit probe);
        if (want) begin
            chk(rd_req_o[idx], "R3 request after issue", rd_req_o[idx], 1);
            repeat (dly) begin
                @(negedge clk);
                chk(rd_req_o[idx], "R3 request held in stall", rd_req_o[idx], 1);
            end
            rd_go_i[idx] = 1'b1;
            src_data_i[idx*DW +: DW] = val;
            #1;
            chk(ex_opnd_o[idx*DW +: DW] == val, "R4 pass-through in go cycle",
                ex_opnd_o[idx*DW +: DW], val);
            @(negedge clk);
            rd_go_i[idx] = 1'b0;
            src_data_i[idx*DW +: DW] = '0;
            chk(!rd_req_o[idx], "R3 request falls after go", rd_req_o[idx], 0);
            if (probe) begin
                rd_go_i[idx] = 1'b1;
                src_data_i[idx*DW +: DW] = 16'hDEAD;
                #1;
                chk(ex_opnd_o[idx*DW +: DW] == val, "R4 go ignored without request",
                    ex_opnd_o[idx*DW +: DW], val);
                @(negedge clk);
                rd_go_i[idx] = 1'b0;
                src_data_i[idx*DW +: DW] = '0;
                chk(!rd_req_o[idx], "R8 no re-rise", rd_req_o[idx], 0);
            end
        end else begin
            repeat (2) begin
                chk(!rd_req_o[idx], "R5/R6/R7 request suppressed", rd_req_o[idx], 0);
                @(negedge clk);
            end
        end
    endtask

    task automatic do_op(input logic [FW-1:0] f, input logic [DW-1:0] a,
        input logic [DW-1:0] b, input logic [DW-1:0] c, input logic [DW-1:0] imm,
        input bit imm_en, input bit zero_a, input logic [NS-1:0] mask,
        input int d0, input int d1, input int d2, input int wd, input int xs,
        input bit probe);
        bit w0, w1, w2;
        logic [DW-1:0] ea, eb, ec, e;
        int cyc;
        w0 = !zero_a && !mask[0];
        w1 = !imm_en && !mask[1];
        w2 = !mask[2];
        ea = w0 ? a : '0;
        eb = imm_en ? imm : (w1 ? b : '0);
        ec = w2 ? c : '0;
        e = calc(f, ea, eb, ec);
        exp_q.push_back(e);
        cur_func = f;
        ex_stall = xs;
        wr_dly = wd;
        @(negedge clk);
        chk(!busy_o, "R1 busy low before issue", busy_o, 0);
        issue_i = 1'b1;
        op_func_i = f;
        op_imm_i = imm;
        op_imm_en_i = imm_en;
        op_zero_a_i = zero_a;
        op_rd_mask_i = mask;
        @(negedge clk);
        issue_i = 1'b0;
        op_func_i = '1;
        op_imm_i = 16'hBEEF;
        op_imm_en_i = 1'b0;
        op_zero_a_i = 1'b0;
        chk(busy_o, "R1 busy after issue", busy_o, 1);
        cyc = 1;
        fork
            serve(0, w0, a, d0, probe);
            serve(1, w1, b, d1, 1'b0);
            serve(2, w2, c, d2, 1'b0);
        join
        while (busy_o && cyc < 200) begin
            @(negedge clk);
            cyc++;
        end
        chk(!busy_o, "R10 operation finished", busy_o, 0);
        if (d0 == 0 && d1 == 0 && d2 == 0 && wd == 0 && xs == 0 && !probe)
            chk(cyc <= 50, "R12 prompt completion", cyc, 50);
        op_rd_mask_i = '0;
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk(!busy_o && rd_req_o == '0 && !ex_valid_o && !wr_req_o,
            "R11 reset state", {busy_o, rd_req_o, ex_valid_o, wr_req_o}, 0);
        repeat (4) begin
            @(negedge clk);
            chk(!busy_o, "R1 no busy without issue", busy_o, 0);
        end
        do_op(4'd0, 16'd5, 16'd2, 16'd7, 16'd0, 0, 0, 3'b000, 0, 0, 0, 0, 0, 0);
        do_op(4'd1, 16'd100, 16'd58, 16'd9, 16'd0, 0, 0, 3'b000, 2, 0, 3, 2, 1, 1);
        do_op(4'd2, 16'd3, 16'd99, 16'd1, 16'd4, 1, 0, 3'b000, 1, 0, 0, 0, 0, 0);
        do_op(4'd0, 16'd77, 16'd2, 16'd3, 16'd0, 0, 1, 3'b000, 0, 1, 1, 1, 0, 0);
        do_op(4'd3, 16'hF0F0, 16'h0FF0, 16'h1234, 16'd0, 0, 0, 3'b100, 0, 0, 0, 0, 0, 0);
        do_op(4'd0, 16'd11, 16'd22, 16'd9, 16'd0, 0, 0, 3'b011, 0, 0, 4, 0, 0, 0);
        do_op(4'd0, 16'd50, 16'd60, 16'd1, 16'd8, 1, 1, 3'b011, 0, 0, 0, 0, 0, 0);
        do_op(4'd1, 16'd5, 16'd6, 16'd7, 16'd0, 0, 0, 3'b111, 0, 0, 0, 0, 0, 0);
        do_op(4'd3, 16'hAAAA, 16'h5555, 16'h0F0F, 16'd0, 0, 0, 3'b000, 5, 5, 5, 3, 4, 1);
        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R10 all results written", exp_q.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule